// File: doc/BRIEF.md
# Rotating Register Renamer

This block turns the virtual register numbers that instructions carry into physical register numbers. It handles three register classes: general, floating-point and predicate. Each class has its own rotating base. A register below its class's rotating region keeps its number. A register inside the region is moved by the class base, and the result wraps inside the region. The lookup is combinational, so a number given in a cycle is translated in that same cycle.

A loop-branch command steps all three bases down by one at the same clock edge. This gives software-pipelined loops a fresh set of registers on every iteration without copy instructions. A clear command sets all three bases back to zero. The floating-point and predicate regions are fixed at the upper three quarters of their files. The general region starts at register 32, and its size is programmed in groups of eight registers.

Top module: `rot_renamer`

## Requirements
- R1: Static registers keep their numbers: general and floating-point 0..31, and predicate 0..15.
- R2: A floating-point virtual number v from 32 to 127 maps to 32 + ((v - 32 + frRrb) mod 96). With frRrb = 95, which is -1, v = 32 gives 127 and v = 35 gives 34.
- R3: A predicate virtual number v from 16 to 63 maps to 16 + ((v - 16 + prRrb) mod 48).
- R4: The general rotating size S is 8 * grSorGroups, limited to 96. A general v in [32, 32+S) maps to 32 + ((v - 32 + grRrb) mod S). A general v at or above 32+S keeps its number.
- R5: A rotate command moves each base to base - 1 at the next clock edge. A base of 0 moves to its region size minus one. The bases can be read on grRrb, frRrb and prRrb.
- R6: A clear command sets all three bases to 0 at the next edge, and clear takes priority over a rotate given in the same cycle.
- R7: After reset all three bases are 0, and every number maps to itself.
- R8: With grSorGroups = 0, general rotation is off: grRrb stays at 0 through rotates, and every general number maps to itself.
- R9: A general base that is not below the current size S (left over after S was made smaller) is treated as 0 for renaming. A rotate from such a base moves it to S - 1.
- R10: Renaming is combinational. A base change appears in the outputs after the clock edge that takes the command, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rotateCmd | input | 1 | Loop-branch rotate: decrement all bases |
| clearCmd | input | 1 | Reset all bases to zero |
| grSorGroups | input | 4 | General rotating size in groups of 8 |
| grVirt | input | 7 | General virtual register number |
| frVirt | input | 7 | Floating-point virtual register number |
| prVirt | input | 6 | Predicate virtual register number |
| grPhys | output | 7 | General physical register number |
| frPhys | output | 7 | Floating-point physical register number |
| prPhys | output | 6 | Predicate physical register number |
| grRrb | output | 7 | Current general rotating base |
| frRrb | output | 7 | Current floating-point rotating base |
| prRrb | output | 6 | Current predicate rotating base |

## Verification
After every base change the bench sweeps every virtual number of all three classes. It does this for more than one full turn of each base, so a wrap placed at the file size instead of the region size would send registers into the static range or past the top of the file. It sets the general size to values that are small, zero and above the limit. A design that rotated the registers above a small general region, or that moved its base while the size is zero, shows up here as a wrong mapping. It also makes the size smaller while the base is large, to catch an out-of-range physical number from a stale base. Finally it gives rotate and clear in the same cycle, which catches a design that lets rotate win.

// File: rtl/rot_renamer_pkg.sv
package rot_renamer_pkg;
  typedef struct packed {
    logic clear;
    logic rotate;
  } rrStrobe_t;
endpackage

// File: rtl/rr_ctrl.sv
module rr_ctrl
  import rot_renamer_pkg::*;
#(
  parameter int GR_SPAN = 96,
  parameter int GPW     = 4,
  parameter int GRW     = 7
) (
  input  logic           rotateCmd,
  input  logic           clearCmd,
  input  logic [GPW-1:0] grSorGroups,
  output rrStrobe_t      strobe,
  output logic [GRW-1:0] grSize
);
  localparam logic [GPW+2:0] SPAN_LIM = (GPW+3)'(GR_SPAN);
  logic [GPW+2:0] rawSize;

  always_comb begin
    strobe.clear  = clearCmd;
    strobe.rotate = rotateCmd & ~clearCmd;  // clear dominates
    rawSize = {grSorGroups, 3'b000};
    if (rawSize > SPAN_LIM) rawSize = SPAN_LIM;
    grSize = GRW'(rawSize);
  end
endmodule

// File: rtl/rr_base.sv
module rr_base
  import rot_renamer_pkg::*;
#(
  parameter int REGS = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  rrStrobe_t          strobe,
  input  logic [$clog2(REGS)-1:0] size,
  output logic [$clog2(REGS)-1:0] rrb
);
  localparam int W = $clog2(REGS);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      rrb <= '0;
    end else if (strobe.rotate) begin
      if (size == '0)
        rrb <= '0;
      else if (rrb == '0 || rrb >= size)
        rrb <= size - W'(1);
      else
        rrb <= rrb - W'(1);
    end
  end
endmodule

// File: rtl/rr_map.sv
module rr_map #(
  parameter int REGS  = 128,
  parameter int FIXED = 32
) (
  input  logic [$clog2(REGS)-1:0] virt,
  input  logic [$clog2(REGS)-1:0] rrb,
  input  logic [$clog2(REGS)-1:0] size,
  output logic [$clog2(REGS)-1:0] phys
);
  localparam int W = $clog2(REGS);
  localparam logic [W:0] FX = (W+1)'(FIXED);

  logic [W:0] offset, effBase, sum, sizeX;

  always_comb begin
    sizeX   = {1'b0, size};
    offset  = {1'b0, virt} - FX;
    effBase = (rrb < size) ? {1'b0, rrb} : '0;
    sum     = offset + effBase;
    if (sum >= sizeX) sum = sum - sizeX;
    phys = virt;
    if ({1'b0, virt} >= FX && offset < sizeX)
      phys = W'(sum + FX);
  end
endmodule

// File: rtl/rot_renamer.sv
module rot_renamer
  import rot_renamer_pkg::*;
#(
  parameter int GR_REGS  = 128,
  parameter int FR_REGS  = 128,
  parameter int FR_FIXED = 32,
  parameter int PR_REGS  = 64,
  parameter int PR_FIXED = 16,
  localparam int GRW     = $clog2(GR_REGS),
  localparam int FRW     = $clog2(FR_REGS),
  localparam int PRW     = $clog2(PR_REGS),
  localparam int GR_SPAN = GR_REGS - 32,
  localparam int GPW     = $clog2(GR_SPAN / 8 + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           rotateCmd,
  input  logic           clearCmd,
  input  logic [GPW-1:0] grSorGroups,
  input  logic [GRW-1:0] grVirt,
  input  logic [FRW-1:0] frVirt,
  input  logic [PRW-1:0] prVirt,
  output logic [GRW-1:0] grPhys,
  output logic [FRW-1:0] frPhys,
  output logic [PRW-1:0] prPhys,
  output logic [GRW-1:0] grRrb,
  output logic [FRW-1:0] frRrb,
  output logic [PRW-1:0] prRrb
);
  localparam logic [FRW-1:0] FR_SIZE = FRW'(FR_REGS - FR_FIXED);
  localparam logic [PRW-1:0] PR_SIZE = PRW'(PR_REGS - PR_FIXED);

  rrStrobe_t      strobe;
  logic [GRW-1:0] grSize;

  rr_ctrl #(.GR_SPAN(GR_SPAN), .GPW(GPW), .GRW(GRW)) u_ctrl (
    .rotateCmd(rotateCmd), .clearCmd(clearCmd), .grSorGroups(grSorGroups),
    .strobe(strobe), .grSize(grSize)
  );

  rr_base #(.REGS(GR_REGS)) u_grBase (
    .clk(clk), .rstN(rstN), .strobe(strobe), .size(grSize), .rrb(grRrb));
  rr_base #(.REGS(FR_REGS)) u_frBase (
    .clk(clk), .rstN(rstN), .strobe(strobe), .size(FR_SIZE), .rrb(frRrb));
  rr_base #(.REGS(PR_REGS)) u_prBase (
    .clk(clk), .rstN(rstN), .strobe(strobe), .size(PR_SIZE), .rrb(prRrb));

  rr_map #(.REGS(GR_REGS), .FIXED(32)) u_grMap (
    .virt(grVirt), .rrb(grRrb), .size(grSize), .phys(grPhys));
  rr_map #(.REGS(FR_REGS), .FIXED(FR_FIXED)) u_frMap (
    .virt(frVirt), .rrb(frRrb), .size(FR_SIZE), .phys(frPhys));
  rr_map #(.REGS(PR_REGS), .FIXED(PR_FIXED)) u_prMap (
    .virt(prVirt), .rrb(prRrb), .size(PR_SIZE), .phys(prPhys));
endmodule

// File: rtl/rot_renamer_chk.sv
module rot_renamer_chk #(
  parameter int GR_REGS  = 128,
  parameter int FR_REGS  = 128,
  parameter int FR_FIXED = 32,
  parameter int PR_REGS  = 64,
  parameter int PR_FIXED = 16,
  localparam int GRW     = $clog2(GR_REGS),
  localparam int FRW     = $clog2(FR_REGS),
  localparam int PRW     = $clog2(PR_REGS),
  localparam int GPW     = $clog2((GR_REGS - 32) / 8 + 1)
) (
  input logic           clk,
  input logic           rstN,
  input logic           rotateCmd,
  input logic           clearCmd,
  input logic [GPW-1:0] grSorGroups,
  input logic [GRW-1:0] grVirt,
  input logic [FRW-1:0] frVirt,
  input logic [PRW-1:0] prVirt,
  input logic [GRW-1:0] grPhys,
  input logic [FRW-1:0] frPhys,
  input logic [PRW-1:0] prPhys,
  input logic [GRW-1:0] grRrb,
  input logic [FRW-1:0] frRrb,
  input logic [PRW-1:0] prRrb
);
  localparam logic [FRW-1:0] FR_TOP = FRW'(FR_REGS - FR_FIXED - 1);

  a_r1_fr_static: assert property (@(posedge clk) disable iff (!rstN)
    (frVirt < FRW'(FR_FIXED)) |-> (frPhys == frVirt));
  a_r1_pr_static: assert property (@(posedge clk) disable iff (!rstN)
    (prVirt < PRW'(PR_FIXED)) |-> (prPhys == prVirt));
  a_r2_fr_in_region: assert property (@(posedge clk) disable iff (!rstN)
    (frVirt >= FRW'(FR_FIXED)) |-> (frPhys >= FRW'(FR_FIXED)));
  a_r5_fr_step: assert property (@(posedge clk) disable iff (!rstN)
    (rotateCmd && !clearCmd && frRrb != '0) |=> (frRrb == $past(frRrb) - FRW'(1)));
  a_r5_fr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rotateCmd && !clearCmd && frRrb == '0) |=> (frRrb == FR_TOP));
  a_r6_clear: assert property (@(posedge clk) disable iff (!rstN)
    clearCmd |=> (grRrb == '0 && frRrb == '0 && prRrb == '0));
  a_r8_gr_off: assert property (@(posedge clk) disable iff (!rstN)
    (grSorGroups == '0 && grRrb == '0) |-> (grPhys == grVirt));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!rotateCmd && !clearCmd) |=> ($stable(frRrb) && $stable(prRrb)));
endmodule

bind rot_renamer rot_renamer_chk #(
  .GR_REGS(GR_REGS), .FR_REGS(FR_REGS), .FR_FIXED(FR_FIXED),
  .PR_REGS(PR_REGS), .PR_FIXED(PR_FIXED)
) u_chk (
  .clk(clk), .rstN(rstN), .rotateCmd(rotateCmd), .clearCmd(clearCmd),
  .grSorGroups(grSorGroups), .grVirt(grVirt), .frVirt(frVirt), .prVirt(prVirt),
  .grPhys(grPhys), .frPhys(frPhys), .prPhys(prPhys),
  .grRrb(grRrb), .frRrb(frRrb), .prRrb(prRrb)
);

// File: tb/rot_renamer_bench.sv
`timescale 1ns/100ps
module rot_renamer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rotateCmd = 1'b0, clearCmd = 1'b0;
  logic [3:0] grSorGroups = 4'd12;
  logic [6:0] grVirt = '0, frVirt = '0;
  logic [5:0] prVirt = '0;
  logic [6:0] grPhys, frPhys, grRrb, frRrb;
  logic [5:0] prPhys, prRrb;

  int checks = 0, failures = 0;
  int mGr = 0, mFr = 0, mPr = 0;

  always #2.5 clk = ~clk;

  rot_renamer u_rot_renamer (
    .clk(clk), .rstN(rstN), .rotateCmd(rotateCmd), .clearCmd(clearCmd),
    .grSorGroups(grSorGroups), .grVirt(grVirt), .frVirt(frVirt), .prVirt(prVirt),
    .grPhys(grPhys), .frPhys(frPhys), .prPhys(prPhys),
    .grRrb(grRrb), .frRrb(frRrb), .prRrb(prRrb));

  function automatic int grSz();
    int s = 8 * int'(grSorGroups);
    return (s > 96) ? 96 : s;
  endfunction

  function automatic int expMap(int v, int fixed, int size, int rrb);
    int eff;
    if (v < fixed || v >= fixed + size) return v;
    eff = (rrb < size) ? rrb : 0;
    return fixed + ((v - fixed + eff) % size);
  endfunction

  function automatic int nextBase(int rrb, int size);
    if (size == 0) return 0;
    if (rrb == 0 || rrb >= size) return size - 1;
    return rrb - 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkBases(string req);
    chk(req, int'(grRrb), mGr);
    chk(req, int'(frRrb), mFr);
    chk(req, int'(prRrb), mPr);
  endtask

  // full sweep of every virtual number in each class (R1 R2 R3 R4)
  task automatic sweep();
    for (int v = 0; v < 128; v++) begin
      grVirt = 7'(v); frVirt = 7'(v); prVirt = 6'(v % 64);
      #0.1;
      chk(v < 32 ? "R1 fr" : "R2 fr", int'(frPhys), expMap(v, 32, 96, mFr));
      chk(v < 32 ? "R1 gr" : "R4 gr", int'(grPhys), expMap(v, 32, grSz(), mGr));
      if (v < 64) chk(v < 16 ? "R1 pr" : "R3 pr", int'(prPhys), expMap(v, 16, 48, mPr));
    end
  endtask

  // one command cycle; R10: bases unchanged before the edge, updated after
  task automatic cmd(logic rot, logic clr);
    @(negedge clk);
    rotateCmd = rot; clearCmd = clr;
    #1;
    checkBases("R10 pre-edge");
    @(posedge clk);
    if (clr) begin mGr = 0; mFr = 0; mPr = 0; end
    else if (rot) begin
      mGr = nextBase(mGr, grSz()); mFr = nextBase(mFr, 96); mPr = nextBase(mPr, 48);
    end
    #1;
    rotateCmd = 1'b0; clearCmd = 1'b0;
    checkBases(clr ? "R6 bases" : "R5 bases");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    checkBases("R7 reset");
    sweep();
    // R2 example: one rotate, fr 32 -> 127, 35 -> 34
    cmd(1'b1, 1'b0);
    frVirt = 7'd32; #0.1; chk("R2 example 32", int'(frPhys), 127);
    frVirt = 7'd35; #0.1; chk("R2 example 35", int'(frPhys), 34);
    // R5 wrap of every class (past 48 and 96)
    for (int i = 0; i < 100; i++) begin cmd(1'b1, 1'b0); sweep(); end
    // R6 clear and rotate together: clear wins
    cmd(1'b1, 1'b1); sweep();
    // R4 small region: 16 registers, pass-through above 48
    grSorGroups = 4'd2;
    for (int i = 0; i < 20; i++) begin cmd(1'b1, 1'b0); sweep(); end
    // R9 stale base after shrinking the size
    cmd(1'b0, 1'b1);
    grSorGroups = 4'd12;
    for (int i = 0; i < 3; i++) cmd(1'b1, 1'b0);
    grSorGroups = 4'd1;
    #0.1; sweep();
    cmd(1'b1, 1'b0);
    chk("R9 stale rotate", int'(grRrb), 7);
    sweep();
    // R8 size zero disables general rotation
    grSorGroups = 4'd0;
    for (int i = 0; i < 3; i++) begin cmd(1'b1, 1'b0); sweep(); end
    chk("R8 base held", int'(grRrb), 0);
    // R4 size limit above 12 groups
    grSorGroups = 4'd15;
    for (int i = 0; i < 4; i++) begin cmd(1'b1, 1'b0); sweep(); end
    cmd(1'b0, 1'b1); sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule